// File: doc/BRIEF.md
# Access Activity Indicator Controller

This block drives the activity lights of a read-only store whose words are spread over four pages. Each page carries 16 row lights, one for each word on the page, and 16 bit lights, one for each bit of a word. When a read completes, the host pulses an access strobe together with the page number, the row number and the 16-bit word that was returned. The block then lights, on that page only, the light for that row and the bit lights for every one-bit of the word. Whatever another page showed before goes dark at the same time.

The display can hold until the next read, or it can switch itself off after a hold time. The hold time is a count of clock ticks, sampled when each access is captured. A value of zero means "hold until the next access". A new access that arrives while a timeout is running replaces the display and restarts the timer from the newly sampled hold time. The block has a control part, which owns the hold timer and issues load and clear strobes, and a datapath, which keeps the displayed page, row and word and decodes them into the per-page light enables.

Top module: `access_led_ctrl`

## Requirements
- R1: After reset, all 64 row enables and all 64 bit enables are 0.
- R2: After an access to page p and row r, row enable index p*16+r is the only row enable that is 1.
- R3: After an access to page p with data word d, the bit enables at indices p*16 to p*16+15 equal d, with bit b of d at index p*16+b. All other bit enables are 0.
- R4: At no time does any page other than the one most recently accessed show a lit row or bit enable.
- R5: A new access to any page replaces the display in full. The lights of the previously shown page are cleared on the same edge.
- R6: If the hold time sampled with the last access is 0, the display stays unchanged for as long as no further access arrives.
- R7: If the sampled hold time is H > 0, the display stays lit for exactly H clock cycles after the capturing edge and is then fully dark.
- R8: An access made while a timeout is running reloads the timer from the hold time sampled with that access.
- R9: Changes to the hold-time input between accesses have no effect on a display that is already showing.
- R10: The outputs change on the clock edge that samples the strobe, and not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accessStrobe | input | 1 | One-cycle pulse marking a completed read |
| accessPage | input | 2 | Page number of the read, 0 to 3 |
| accessRow | input | 4 | Row (word) number within the page |
| accessData | input | 16 | Word returned by the read |
| holdTicks | input | 16 | Hold time in clock ticks; 0 holds until the next access |
| rowLeds | output | 64 | Row light enables; page p row r at index p*16+r |
| bitLeds | output | 64 | Bit light enables; page p bit b at index p*16+b |

## Verification
On every cycle, the assertions check the following: only one row light is lit whenever any bit light is on; bit lights appear only on a page whose row light is lit; the page, row and word captured at each access appear on the next cycle; a zero hold keeps the display frozen; and a checker-side countdown matches the instants at which the lights go dark. Some behaviours can only be shown by the bench's scenarios. These are the reset state, the sweep over every page and row with varied words, the exact expiry cycle for a range of hold times, the restart of a timeout by a second access, and the fact that changing the hold input during a timeout has no effect.

// File: rtl/ledctl_pkg.sv
package ledctl_pkg;
  // Strobes from the control part to the display datapath
  typedef struct packed {
    logic load;   // capture a new access into the display
    logic clear;  // blank the display (timeout expired)
  } ledStrobes_t;
endpackage

// File: rtl/ledctl_ctrl.sv
module ledctl_ctrl
  import ledctl_pkg::*;
#(
  parameter int TIMER_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               accessStrobe,
  input  logic [TIMER_W-1:0] holdTicks,
  output ledStrobes_t        strobes
);
  localparam logic [TIMER_W-1:0] ONE = TIMER_W'(1);

  logic [TIMER_W-1:0] remain;
  logic               armed;
  logic               lastTick;

  assign lastTick      = armed && (remain == ONE);
  assign strobes.load  = accessStrobe;
  assign strobes.clear = !accessStrobe && lastTick;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remain <= '0;
      armed  <= 1'b0;
    end else if (accessStrobe) begin
      remain <= holdTicks;
      armed  <= (holdTicks != '0);
    end else if (armed) begin
      remain <= remain - ONE;
      if (lastTick) armed <= 1'b0;
    end
  end
endmodule

// File: rtl/ledctl_data.sv
module ledctl_data
  import ledctl_pkg::*;
#(
  parameter int NUM_PAGES = 4,
  parameter int ROWS      = 16,
  parameter int DATA_W    = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ledStrobes_t                 strobes,
  input  logic [$clog2(NUM_PAGES)-1:0] accessPage,
  input  logic [$clog2(ROWS)-1:0]      accessRow,
  input  logic [DATA_W-1:0]           accessData,
  output logic [NUM_PAGES*ROWS-1:0]   rowLeds,
  output logic [NUM_PAGES*DATA_W-1:0] bitLeds
);
  localparam int PAGE_W = $clog2(NUM_PAGES);
  localparam int ROW_W  = $clog2(ROWS);

  logic              litValid;
  logic [PAGE_W-1:0] litPage;
  logic [ROW_W-1:0]  litRow;
  logic [DATA_W-1:0] litData;
  logic [ROWS-1:0]   rowOneHot;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      litValid <= 1'b0;
      litPage  <= '0;
      litRow   <= '0;
      litData  <= '0;
    end else if (strobes.load) begin
      litValid <= 1'b1;
      litPage  <= accessPage;
      litRow   <= accessRow;
      litData  <= accessData;
    end else if (strobes.clear) begin
      litValid <= 1'b0;
    end
  end

  always_comb begin
    rowOneHot = '0;
    rowOneHot[litRow] = 1'b1;
  end

  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
    logic pageHit;
    assign pageHit = litValid && (litPage == PAGE_W'(p));
    assign rowLeds[p*ROWS +: ROWS]     = pageHit ? rowOneHot : '0;
    assign bitLeds[p*DATA_W +: DATA_W] = pageHit ? litData   : '0;
  end
endmodule

// File: rtl/access_led_ctrl.sv
module access_led_ctrl
  import ledctl_pkg::*;
#(
  parameter int NUM_PAGES = 4,
  parameter int ROWS      = 16,
  parameter int DATA_W    = 16,
  parameter int TIMER_W   = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         accessStrobe,
  input  logic [$clog2(NUM_PAGES)-1:0] accessPage,
  input  logic [$clog2(ROWS)-1:0]      accessRow,
  input  logic [DATA_W-1:0]            accessData,
  input  logic [TIMER_W-1:0]           holdTicks,
  output logic [NUM_PAGES*ROWS-1:0]    rowLeds,
  output logic [NUM_PAGES*DATA_W-1:0]  bitLeds
);
  ledStrobes_t strobes;

  ledctl_ctrl #(.TIMER_W(TIMER_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .accessStrobe(accessStrobe),
    .holdTicks(holdTicks), .strobes(strobes)
  );

  ledctl_data #(.NUM_PAGES(NUM_PAGES), .ROWS(ROWS), .DATA_W(DATA_W)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .accessPage(accessPage), .accessRow(accessRow), .accessData(accessData),
    .rowLeds(rowLeds), .bitLeds(bitLeds)
  );
endmodule

// File: rtl/access_led_checker.sv
module access_led_checker #(
  parameter int NUM_PAGES = 4,
  parameter int ROWS      = 16,
  parameter int DATA_W    = 16,
  parameter int TIMER_W   = 16
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         accessStrobe,
  input logic [$clog2(NUM_PAGES)-1:0] accessPage,
  input logic [$clog2(ROWS)-1:0]      accessRow,
  input logic [DATA_W-1:0]            accessData,
  input logic [TIMER_W-1:0]           holdTicks,
  input logic [NUM_PAGES*ROWS-1:0]    rowLeds,
  input logic [NUM_PAGES*DATA_W-1:0]  bitLeds
);
  localparam int PAGE_W = $clog2(NUM_PAGES);
  localparam int ROW_W  = $clog2(ROWS);

  logic [PAGE_W-1:0]  ckPage;
  logic [ROW_W-1:0]   ckRow;
  logic [DATA_W-1:0]  ckData;
  logic [TIMER_W-1:0] ckHold;
  logic [TIMER_W-1:0] ckRemain;
  logic [ROWS-1:0]    shownRows;
  logic [DATA_W-1:0]  shownData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ckPage <= '0; ckRow <= '0; ckData <= '0; ckHold <= '0; ckRemain <= '0;
    end else if (accessStrobe) begin
      ckPage <= accessPage; ckRow <= accessRow; ckData <= accessData;
      ckHold <= holdTicks;  ckRemain <= holdTicks;
    end else if (ckRemain != '0) begin
      ckRemain <= ckRemain - TIMER_W'(1);
    end
  end

  always_comb begin
    shownRows = '0;
    shownData = '0;
    for (int p = 0; p < NUM_PAGES; p++) begin
      if (ckPage == PAGE_W'(p)) begin
        shownRows = rowLeds[p*ROWS +: ROWS];
        shownData = bitLeds[p*DATA_W +: DATA_W];
      end
    end
  end

  AST_ONE_ROW: assert property (@(posedge clk) disable iff (!rstN)
    (|bitLeds) |-> ($countones(rowLeds) == 1)); // R2

  AST_LOAD_ROW: assert property (@(posedge clk) disable iff (!rstN)
    accessStrobe |=> (shownRows[ckRow] && $countones(rowLeds) == 1)); // R2

  AST_LOAD_DATA: assert property (@(posedge clk) disable iff (!rstN)
    accessStrobe |=> ((shownData == ckData) && ($countones(bitLeds) == $countones(ckData)))); // R3

  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_pg
    AST_PAGE_ALONE: assert property (@(posedge clk) disable iff (!rstN)
      (|bitLeds[p*DATA_W +: DATA_W]) |-> (|rowLeds[p*ROWS +: ROWS])); // R4
  end

  AST_HOLD_FOREVER: assert property (@(posedge clk) disable iff (!rstN)
    (!accessStrobe && (ckHold == '0)) |=> ($stable(rowLeds) && $stable(bitLeds))); // R6

  AST_LIT_WHILE_TIMING: assert property (@(posedge clk) disable iff (!rstN)
    (ckRemain != '0) |-> (rowLeds != '0)); // R7

  AST_DARK_AFTER_EXPIRY: assert property (@(posedge clk) disable iff (!rstN)
    ((ckHold != '0) && (ckRemain == '0)) |-> ((rowLeds == '0) && (bitLeds == '0))); // R7
endmodule

bind access_led_ctrl access_led_checker u_chk (
  .clk(clk), .rstN(rstN), .accessStrobe(accessStrobe), .accessPage(accessPage),
  .accessRow(accessRow), .accessData(accessData), .holdTicks(holdTicks),
  .rowLeds(rowLeds), .bitLeds(bitLeds)
);

// File: tb/tb_access_led_ctrl.sv
module tb_access_led_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accessStrobe = 1'b0;
  logic [1:0]  accessPage = '0;
  logic [3:0]  accessRow = '0;
  logic [15:0] accessData = '0;
  logic [15:0] holdTicks = '0;
  logic [63:0] rowLeds, bitLeds;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  access_led_ctrl dut (
    .clk(clk), .rstN(rstN), .accessStrobe(accessStrobe), .accessPage(accessPage),
    .accessRow(accessRow), .accessData(accessData), .holdTicks(holdTicks),
    .rowLeds(rowLeds), .bitLeds(bitLeds)
  );

  task automatic checkShow(input bit lit, input int page, input int row,
                           input logic [15:0] data, input string tag);
    logic [63:0] expRow, expBit;
    expRow = lit ? (64'd1 << (page*16 + row)) : 64'd0;
    expBit = lit ? ({48'd0, data} << (page*16)) : 64'd0;
    checks++;
    if (rowLeds !== expRow || bitLeds !== expBit) begin
      fails++;
      $display("FAIL %s: rows=%h bits=%h expected rows=%h bits=%h",
               tag, rowLeds, bitLeds, expRow, expBit);
    end
  endtask

  // Drive one access at a negedge; returns at the next negedge (display updated)
  task automatic doAccess(input int page, input int row, input logic [15:0] data,
                          input logic [15:0] hold);
    accessPage = 2'(page); accessRow = 4'(row); accessData = data; holdTicks = hold;
    accessStrobe = 1'b1;
    @(negedge clk);
    accessStrobe = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    checkShow(0, 0, 0, 16'h0, "R1 reset dark");

    // R10: inputs applied, no edge yet -> display unchanged
    accessPage = 2'd2; accessRow = 4'd7; accessData = 16'hBEEF; accessStrobe = 1'b1;
    #1 checkShow(0, 0, 0, 16'h0, "R10 before edge");
    @(negedge clk);
    accessStrobe = 1'b0;
    checkShow(1, 2, 7, 16'hBEEF, "R10 after edge");

    // R2/R3/R4/R5 sweep over every page and row, hold forever
    for (int p = 0; p < 4; p++) begin
      for (int r = 0; r < 16; r++) begin
        logic [15:0] d;
        d = 16'((r * 16'h1111) ^ (p * 16'h0F0F) ^ (16'h8001 >> r));
        doAccess(p, r, d, 16'd0);
        checkShow(1, p, r, d, "R2 R3 R4 R5 sweep");
      end
    end

    // R6: hold forever for a long idle stretch
    doAccess(1, 9, 16'hA5A5, 16'd0);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (i % 10 == 9) checkShow(1, 1, 9, 16'hA5A5, "R6 hold forever");
    end

    // R7: exact expiry for a range of hold times
    for (int h = 1; h <= 7; h++) begin
      logic [15:0] d;
      d = 16'(h * 16'h2481);
      doAccess(h % 4, 15 - h, d, 16'(h));
      for (int c = 1; c < h; c++) begin
        @(negedge clk);
        checkShow(1, h % 4, 15 - h, d, "R7 lit during hold");
      end
      @(negedge clk);
      checkShow(0, 0, 0, 16'h0, "R7 dark after hold");
      repeat (3) @(negedge clk);
      checkShow(0, 0, 0, 16'h0, "R7 stays dark");
    end

    // R8: second access during running timeout restarts it
    doAccess(0, 3, 16'h1234, 16'd4);
    repeat (2) @(negedge clk);
    doAccess(3, 12, 16'hFFFF, 16'd5);
    for (int c = 1; c < 5; c++) begin
      @(negedge clk);
      checkShow(1, 3, 12, 16'hFFFF, "R8 reloaded timer lit");
    end
    @(negedge clk);
    checkShow(0, 0, 0, 16'h0, "R8 reloaded timer expiry");

    // R8: access with hold 0 during timeout cancels it
    doAccess(2, 0, 16'h0001, 16'd3);
    doAccess(2, 1, 16'h8000, 16'd0);
    repeat (6) @(negedge clk);
    checkShow(1, 2, 1, 16'h8000, "R8 cancel timeout");

    // R9: hold input changes after capture have no effect
    doAccess(1, 5, 16'h0F0F, 16'd3);
    holdTicks = 16'd0;
    @(negedge clk);
    holdTicks = 16'd100;
    @(negedge clk);
    checkShow(1, 1, 5, 16'h0F0F, "R9 still lit");
    @(negedge clk);
    checkShow(0, 0, 0, 16'h0, "R9 expiry unaffected");

    // R1: reset mid-display
    doAccess(3, 3, 16'h3333, 16'd0);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    checkShow(0, 0, 0, 16'h0, "R1 reset clears display");

    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule